// File: doc/BRIEF.md
# Three-Wire Nibble Clock-Chip Serial Master

This block is the host side of a three-wire serial link to a real-time clock chip whose registers are four bits wide. A caller gives it one register operation at a time: a read or a write, a 4-bit register address and, for writes, a 4-bit value. The block turns that operation into command bytes on a clock line and a shared data line, and returns the read nibble with a one-cycle completion strobe.

Each command byte carries flag bits that mark it as an address byte, a data byte or a read. The data line is driven by the host only while it sends a byte. The host lets go of the line between bytes, and during a read it releases the line so the chip can answer. The bit clock comes from a half-period counter in system clock cycles. The chip-enable output simply mirrors an enable input held by the caller, who also owns any multi-register sequencing and number-format conversion.

Top module: `rtc3w_master`

## Requirements
- R1: After synchronous reset, and whenever the block is not busy, the clock line is high, the data output enable is low, and busy and done are low.
- R2: Every byte is shifted out or in as exactly eight bits, most significant bit first.
- R3: Each bit has two phases of exactly HALF_CYC system cycles: the clock line high with the bit on the data line, then the clock line low. The data line does not change while the clock line is low.
- R4: The data output enable rises together with the first bit of each transmitted byte and falls after the eighth bit. Between two transmitted bytes it is low for two cycles.
- R5: A read sends one command byte equal to 0x60 OR the address (bit 6 = read flag, bit 5 = address flag, bits 3:0 = address). It then keeps the data output enable low while eight bits are clocked in.
- R6: During a read, each incoming bit is sampled at the end of the clock-high phase, before the clock line falls.
- R7: The read result is the low four bits of the received byte. The upper four received bits are discarded.
- R8: A write sends two bytes: 0x20 OR the address, then 0x10 OR the write value (bit 4 = data flag, bits 3:0 = value).
- R9: Busy rises in the cycle after a request is accepted and stays high until done. Done is a one-cycle pulse seen 32*HALF_CYC+4 cycles after the accepting edge, counting that edge as cycle 1. Reads and writes take the same time.
- R10: A request presented while busy is ignored. The transaction in progress is not changed, and no further transaction follows it.
- R11: The chip-enable output equals the enable input. A request is accepted only while the enable input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Caller enable; gates requests and drives chip enable |
| req_valid_i | input | 1 | Request strobe, taken when idle and enabled |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 4 | Write value |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_nibble_o | output | 4 | Nibble returned by the last read |
| ce_o | output | 1 | Chip enable to the clock chip |
| scl_o | output | 1 | Serial bit clock |
| sda_o | output | 1 | Serial data out |
| sda_oe_o | output | 1 | Serial data output enable |
| sda_i | input | 1 | Serial data in |

## Verification
Done is due on cycle 32*HALF_CYC+4, counting the accepting edge as cycle 1. The bench counts falling clock edges from that edge and compares the count at the moment done appears, so a stretched or shortened phase shows up as a wrong count. The bench model records the bytes on the line at each falling clock edge. It presents each reply bit right after a falling edge, so the reply is correct only if the block samples at the end of the high phase. The read nibble and the ignored-request results are checked after done has been seen. A separate monitor measures every low phase against HALF_CYC.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

   localparam int NIB_W  = 4;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] FLG_READ = 8'h40;
   localparam logic [BYTE_W-1:0] FLG_ADDR = 8'h20;
   localparam logic [BYTE_W-1:0] FLG_DATA = 8'h10;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_TURN,
      S_DATA,
      S_FIN
   } ctl_state_t;

   typedef struct packed {
      logic             wr;
      logic [NIB_W-1:0] addr;
      logic [NIB_W-1:0] wdata;
   } req_t;

   function automatic logic [BYTE_W-1:0] cmd_byte(input logic wr, input logic [NIB_W-1:0] a);
      logic [BYTE_W-1:0] base;
      base = {{(BYTE_W-NIB_W){1'b0}}, a};
      return wr ? (base | FLG_ADDR) : (base | FLG_ADDR | FLG_READ);
   endfunction

   function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] d);
      return {{(BYTE_W-NIB_W){1'b0}}, d} | FLG_DATA;
   endfunction

endpackage

// File: rtl/rtc3w_sync.sv
module rtc3w_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0 || STAGES > 3) begin : g_bad_stages
      $error("rtc3w_sync: STAGES must be 0..3");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_flops
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= '1;
         else     chain <= {chain[STAGES-2+1-1:0], d_i} >> 0;
      end
      assign q_o = chain[STAGES-1];
   end

endmodule

// File: rtl/rtc3w_half_timer.sv
module rtc3w_half_timer #(
   parameter int HALF_CYC = 88
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic tick_o
);

   localparam int CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

   if (HALF_CYC < 2) begin : g_bad_half
      $error("rtc3w_half_timer: HALF_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !run_i)   cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick_o = run_i && (cnt == LAST);

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);  // R3

endmodule

// File: rtl/rtc3w_byte_shifter.sv
module rtc3w_byte_shifter
   import rtc3w_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              rx_mode_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   input  logic              sda_s_i,
   input  logic              tick_i,
   output logic              active_o,
   output logic              scl_o,
   output logic              sda_o,
   output logic              sda_oe_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              byte_done_o
);

   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BYTE_W - 1);

   logic              active;
   logic              ph_low;
   logic              rx_mode;
   logic [IDX_W-1:0]  bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         ph_low  <= 1'b0;
         rx_mode <= 1'b0;
         bit_idx <= '0;
         shreg   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!active) begin
            if (start_i) begin
               active  <= 1'b1;
               ph_low  <= 1'b0;
               rx_mode <= rx_mode_i;
               bit_idx <= '0;
               shreg   <= rx_mode_i ? '0 : tx_byte_i;
            end
         end else if (tick_i) begin
            if (!ph_low) begin
               ph_low <= 1'b1;
               if (rx_mode) shreg <= {shreg[BYTE_W-2:0], sda_s_i};
            end else begin
               ph_low <= 1'b0;
               if (bit_idx == LAST_BIT) begin
                  active <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
                  if (!rx_mode) shreg <= {shreg[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign active_o    = active;
   assign scl_o       = !(active && ph_low);
   assign sda_o       = shreg[BYTE_W-1];
   assign sda_oe_o    = active && !rx_mode;
   assign rx_byte_o   = shreg;
   assign byte_done_o = done_q;

   AST_SDA_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
      (!scl_o && $past(!scl_o) && sda_oe_o) |-> $stable(sda_o));  // R3

   AST_END_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> $past(ph_low));  // R2

endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
   import rtc3w_pkg::*;
#(
   parameter int HALF_CYC    = 88,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic             req_valid_i,
   input  logic             req_write_i,
   input  logic [NIB_W-1:0] req_addr_i,
   input  logic [NIB_W-1:0] req_wdata_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NIB_W-1:0] rd_nibble_o,
   output logic             ce_o,
   output logic             scl_o,
   output logic             sda_o,
   output logic             sda_oe_o,
   input  logic             sda_i
);

   if (NIB_W > 4 || BYTE_W != 8) begin : g_bad_widths
      $error("rtc3w_master: nibble must fit below the flag bits of an 8-bit byte");
   end

   ctl_state_t        state;
   req_t              req_q;
   logic [NIB_W-1:0]  rd_q;
   logic              accept;
   logic              start;
   logic              rx_mode;
   logic [BYTE_W-1:0] tx_byte;
   logic              sda_s;
   logic              tick;
   logic              sh_active;
   logic              byte_done;
   logic [BYTE_W-1:0] rx_byte;

   assign accept  = (state == S_IDLE) && req_valid_i && en_i;
   assign start   = accept || (state == S_TURN);
   assign rx_mode = (state == S_TURN) && !req_q.wr;
   assign tx_byte = accept ? cmd_byte(req_write_i, req_addr_i) : data_byte(req_q.wdata);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= S_IDLE;
         req_q <= '0;
         rd_q  <= '0;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               state <= S_CMD;
               req_q <= '{wr: req_write_i, addr: req_addr_i, wdata: req_wdata_i};
            end
            S_CMD:  if (byte_done) state <= S_TURN;
            S_TURN: state <= S_DATA;
            S_DATA: if (byte_done) begin
               state <= S_FIN;
               if (!req_q.wr) rd_q <= rx_byte[NIB_W-1:0];
            end
            S_FIN:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   rtc3w_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d_i (sda_i),
      .q_o (sda_s)
   );

   rtc3w_half_timer #(.HALF_CYC(HALF_CYC)) i_timer (
      .clk    (clk),
      .rst    (rst),
      .run_i  (sh_active),
      .tick_o (tick)
   );

   rtc3w_byte_shifter i_shift (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .rx_mode_i   (rx_mode),
      .tx_byte_i   (tx_byte),
      .sda_s_i     (sda_s),
      .tick_i      (tick),
      .active_o    (sh_active),
      .scl_o       (scl_o),
      .sda_o       (sda_o),
      .sda_oe_o    (sda_oe_o),
      .rx_byte_o   (rx_byte),
      .byte_done_o (byte_done)
   );

   assign busy_o      = (state != S_IDLE);
   assign done_o      = (state == S_FIN);
   assign rd_nibble_o = rd_q;
   assign ce_o        = en_i;

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (scl_o && !sda_oe_o));  // R1

   AST_RX_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (state == S_DATA && !req_q.wr) |-> !sda_oe_o);  // R5

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);  // R9

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      (busy_o && $past(busy_o)) |-> $stable(req_q));  // R10

endmodule

// File: tb/test_rtc3w_master.sv
module test_rtc3w_master;

   localparam int H   = 3;
   localparam int LAT = 32 * H + 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [3:0] req_wdata = '0;
   logic       busy, done, ce, scl, sda, sda_oe;
   logic [3:0] rd_nib;
   logic       sda_in;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rtc3w_master #(.HALF_CYC(H), .SYNC_STAGES(2)) i_rtc3w_master (
      .clk (clk), .rst (rst), .en_i (en), .req_valid_i (req_valid),
      .req_write_i (req_write), .req_addr_i (req_addr), .req_wdata_i (req_wdata),
      .busy_o (busy), .done_o (done), .rd_nibble_o (rd_nib), .ce_o (ce),
      .scl_o (scl), .sda_o (sda), .sda_oe_o (sda_oe), .sda_i (sda_in)
   );

   // Chip model: records transmitted bits, answers reads.
   logic [7:0] cap_bytes [4];
   int         cap_n = 0;
   int         cap_bits = 0;
   logic [7:0] cap_sh = '0;
   int         oe_rises = 0;
   int         rx_falls = 0;
   logic [7:0] resp = '0;

   always @(negedge scl) begin
      if (sda_oe) begin
         cap_sh = {cap_sh[6:0], sda};
         cap_bits++;
         if (cap_bits == 8) begin
            if (cap_n < 4) cap_bytes[cap_n] = cap_sh;
            cap_n++;
            cap_bits = 0;
         end
      end else begin
         rx_falls++;
      end
   end

   always @(posedge sda_oe) oe_rises++;

   assign sda_in = (rx_falls < 8) ? resp[7 - rx_falls] : 1'b1;

   // Low-phase length monitor.
   int low_run = 0;
   int low_bad = 0;
   int low_seen = 0;
   always @(negedge clk) begin
      if (!scl) low_run++;
      else begin
         if (low_run != 0) begin
            low_seen++;
            if (low_run != H) low_bad++;
         end
         low_run = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_model(input logic [7:0] r);
      cap_n = 0; cap_bits = 0; oe_rises = 0; rx_falls = 0; resp = r;
   endtask

   // Runs one request; returns the cycle on which done was seen.
   task automatic run_txn(input logic wr, input logic [3:0] a, input logic [3:0] d,
                          input logic [7:0] r, input bit poke_busy, output int lat);
      int n;
      @(negedge clk);
      clear_model(r);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
         if (poke_busy && n == 10) begin
            req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
         end
         if (poke_busy && n == 14) req_valid = 1'b0;
      end
      req_valid = 1'b0;
      lat = n;
   endtask

   // {write, addr, wdata, reply byte}
   localparam logic [16:0] VEC [7] = '{
      {1'b1, 4'h0, 4'h0, 8'h00},
      {1'b1, 4'hF, 4'hF, 8'h00},
      {1'b1, 4'h5, 4'hA, 8'h00},
      {1'b0, 4'hE, 4'h0, 8'hA5},
      {1'b0, 4'h3, 4'h0, 8'h3C},
      {1'b0, 4'h0, 4'h0, 8'hFF},
      {1'b0, 4'h7, 4'h0, 8'h5A}
   };

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(scl === 1'b1, "R1 scl after reset", scl, 1);
      chk(sda_oe === 1'b0, "R1 oe after reset", sda_oe, 0);
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
      rst = 1'b0;

      // R11: request with enable low is ignored
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1;
      repeat (10) @(negedge clk);
      chk(busy === 1'b0, "R11 request ignored with enable low", busy, 0);
      chk(ce === 1'b0, "R11 ce follows low enable", ce, 0);
      req_valid = 1'b0;
      en = 1'b1;
      @(negedge clk);
      chk(ce === 1'b1, "R11 ce follows high enable", ce, 1);

      foreach (VEC[i]) begin
         logic wr; logic [3:0] a, d; logic [7:0] r;
         {wr, a, d, r} = VEC[i];
         run_txn(wr, a, d, r, 1'b0, lat);
         chk(lat == LAT, "R9 done latency", lat, LAT);
         if (wr) begin
            chk(cap_n == 2, "R8 write byte count", cap_n, 2);
            chk(cap_bytes[0] == (8'h20 | {4'h0, a}), "R8 R2 write address byte",
                cap_bytes[0], 8'h20 | {4'h0, a});
            chk(cap_bytes[1] == (8'h10 | {4'h0, d}), "R8 R2 write data byte",
                cap_bytes[1], 8'h10 | {4'h0, d});
            chk(oe_rises == 2, "R4 oe released between bytes", oe_rises, 2);
         end else begin
            chk(cap_n == 1, "R5 read sends one byte", cap_n, 1);
            chk(cap_bytes[0] == (8'h60 | {4'h0, a}), "R5 R2 read command byte",
                cap_bytes[0], 8'h60 | {4'h0, a});
            chk(rx_falls == 8, "R5 eight clocks with line released", rx_falls, 8);
            chk(rd_nib == r[3:0], "R7 R6 read nibble", rd_nib, r[3:0]);
         end
         @(negedge clk);
         chk(busy === 1'b0, "R9 busy drops after done", busy, 0);
      end

      // R10: request while busy ignored
      run_txn(1'b1, 4'h9, 4'h6, 8'h00, 1'b1, lat);
      chk(lat == LAT, "R10 latency unchanged by busy request", lat, LAT);
      chk(cap_bytes[0] == 8'h29 && cap_bytes[1] == 8'h16, "R10 bytes unchanged",
          {cap_bytes[0], cap_bytes[1]}, 16'h2916);
      clear_model(8'h00);
      repeat (40) @(negedge clk);
      chk(busy === 1'b0 && oe_rises == 0, "R10 no follow-on transaction", {busy, oe_rises[3:0]}, 0);

      // R3: every low phase lasted HALF_CYC cycles
      chk(low_bad == 0 && low_seen > 0, "R3 low phase length", low_bad, 0);

      // R1: reset in mid-transaction returns bus to idle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h2;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (H * 3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && scl === 1'b1 && sda_oe === 1'b0, "R1 reset mid-transaction",
          {busy, scl, sda_oe}, 3'b010);
      rst = 1'b0;

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule